// File: doc/BRIEF.md
# Shutdown and Wake-Up Controller

This block lives in the always-on slow-clock domain, nominally 32768 Hz, and decides when main power is cut and when it comes back. Software writes a control word that carries an 8-bit key. When the key matches, the block raises a shutdown output that drives the external power switch. While that output is high, the block watches up to sixteen wake pins and two alarm inputs, one from a calendar clock and one from a tick timer. Each wake pin has its own enable and its own active level.

Pin activity passes through a shared debouncer. The period is chosen from six steps, counted in slow-clock cycles. The first enabled event that qualifies drops the shutdown output and leaves a record of its cause in a status word. A read of the status word clears it. Outside shutdown, wake activity has no effect.

The register space is four 32-bit words: control at 0x0, mode at 0x4, status at 0x8 and wake-pin setup at 0xC. Reads are combinational. Writes and read side effects take place at the clock edge that samples the strobe. All inputs are assumed to be synchronous to the slow clock already.

Top module: `shdn_wake_ctrl`

## Requirements
- R1: After reset, `shdn_o` is 0, and the status, mode and wake-pin setup words all read 0, so every wake source is disabled.
- R2: A write to offset 0x0 with bit 0 = 1 and bits 31:24 = 0xA5 sets `shdn_o` to 1 at the clock edge that samples the write.
- R3: A write to offset 0x0 with a key other than 0xA5, or with bit 0 = 0, leaves `shdn_o` unchanged.
- R4: The mode word at 0x4 reads back as written. Bits 26:24 are the debounce index, bit 17 enables the calendar alarm and bit 16 enables the timer alarm.
- R5: The wake-pin setup word at 0xC reads back as written. Bit i (0..15) enables pin i. Bit 16+i sets the active level of pin i: 1 means high, 0 means low.
- R6: Debounce index 0..5 selects a hold of 0, 3, 32, 512, 4096 or 32768 cycles, and indices 6 and 7 act as 5. A pin that first shows its active level at edge k drops `shdn_o` at edge k+N when the hold N is greater than 0, and at edge k when N is 0.
- R7: If the active level of a pin breaks before the hold completes, the count restarts from zero.
- R8: While shut down, a debounced event on an enabled pin i clears `shdn_o` and sets status bit 16+i. Disabled pins never wake.
- R9: While shut down, the calendar alarm wakes only if mode bit 17 is set and then sets status bit 5. The timer alarm wakes only if mode bit 16 is set and then sets status bit 4.
- R10: A read of offset 0x8 returns the status word, and the word reads 0 afterwards unless a new wake is captured in the same cycle.
- R11: While `shdn_o` is 0, pin and alarm activity leaves `shdn_o` and the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on 0x8) |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pins_i | input | 16 | Wake pins, synchronous to clk |
| cal_alarm_i | input | 1 | Calendar clock alarm |
| tick_alarm_i | input | 1 | Tick timer alarm |
| shdn_o | output | 1 | High while main power is to be off |

## Verification
The wake path is tried with several input patterns, and each one separates a different fault:
- A pin held exactly one cycle short of the hold, and a pin that breaks its level midway, both separate a counter that restarts correctly from one that accumulates or fires early.
- A pin held to completion, with the number of edges to wake counted, pins down an off-by-one in the hold for indices 0, 1, 2, 5 and 7.
- Keyed writes with a wrong key or with bit 0 clear separate key checking from a plain write decode.
- Wake activity before shutdown, and alarms whose enable bit is clear, show whether the enables and the shutdown gating are honoured.
- The status cause bits distinguish pin, calendar and timer captures, and active-low pins check the polarity bit.

// File: rtl/shdn_pkg.sv
// Package: shared constants and helpers for the shutdown controller.
// Assumes a 32-bit register bus with byte offsets.
package shdn_pkg;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam int CNT_W       = 16;
    localparam int IDX_W       = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_MODE = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_PINS = 4'hC;

    localparam logic [7:0] SHDN_KEY   = 8'hA5;
    localparam int KEY_LSB            = 24;
    localparam int IDX_LSB            = 24;
    localparam int CAL_EN_BIT         = 17;
    localparam int TICK_EN_BIT        = 16;
    localparam int ST_CAL_BIT         = 5;
    localparam int ST_TICK_BIT        = 4;
    localparam int ST_PIN_LSB         = 16;
    localparam int POL_LSB            = 16;

    // Map a debounce index to a hold length in clock cycles.
    function automatic logic [CNT_W-1:0] hold_cycles(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return CNT_W'(0);
            3'd1:    return CNT_W'(3);
            3'd2:    return CNT_W'(32);
            3'd3:    return CNT_W'(512);
            3'd4:    return CNT_W'(4096);
            default: return CNT_W'(32768);
        endcase
    endfunction
endpackage

// File: rtl/shdn_regs.sv
// Module: register bank. Holds the mode and wake-pin setup words, decodes the
// keyed shutdown write into a one-cycle request, and flags status reads.
// Assumes single-cycle strobes and combinational reads.
module shdn_regs
    import shdn_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stat_i,
    output logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  dbc_idx,
    output logic              cal_en,
    output logic              tick_en,
    output logic [NPIN-1:0]   pin_en,
    output logic [NPIN-1:0]   pin_pol,
    output logic              shdn_req,
    output logic              stat_rd
);
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] pins_q;

    // Store mode and wake-pin setup words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            pins_q <= '0;
        end else if (wr_en) begin
            if (addr == OFF_MODE) mode_q <= wdata;
            if (addr == OFF_PINS) pins_q <= wdata;
        end
    end

    // Decode the keyed shutdown command and the status read side effect.
    always_comb begin
        shdn_req = wr_en && (addr == OFF_CTRL)
                   && (wdata[KEY_LSB +: 8] == SHDN_KEY) && wdata[0];
        stat_rd  = rd_en && (addr == OFF_STAT);
    end

    // Read multiplexer; the control word reads as zero.
    always_comb begin
        case (addr)
            OFF_MODE: rdata = mode_q;
            OFF_STAT: rdata = stat_i;
            OFF_PINS: rdata = pins_q;
            default:  rdata = '0;
        endcase
    end

    // Field extraction for the datapath.
    always_comb begin
        dbc_idx = mode_q[IDX_LSB +: IDX_W];
        cal_en  = mode_q[CAL_EN_BIT];
        tick_en = mode_q[TICK_EN_BIT];
        pin_en  = pins_q[NPIN-1:0];
        pin_pol = pins_q[POL_LSB +: NPIN];
    end
endmodule

// File: rtl/shdn_debounce.sv
// Module: per-pin debouncer with a shared hold length. A pin qualifies once
// its active level has been sampled for the full hold; any break restarts it.
// Assumes pins are already synchronous to clk.
module shdn_debounce
    import shdn_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  pins_i,
    input  logic [NPIN-1:0]  pin_pol,
    input  logic [IDX_W-1:0] dbc_idx,
    output logic [NPIN-1:0]  qual_o
);
    logic [CNT_W-1:0] limit;

    // Shared hold length from the selected index.
    always_comb limit = hold_cycles(dbc_idx);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic             active;
        logic [CNT_W-1:0] cnt_q;

        // Active when the pin matches its configured level.
        always_comb active = (pins_i[i] == pin_pol[i]);

        // Count consecutive active samples, saturating at the hold.
        always_ff @(posedge clk) begin
            if (!rst_n || !active) cnt_q <= '0;
            else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
        end

        // Qualified output: direct with no hold, else after a full hold.
        always_comb qual_o[i] = (limit == '0) ? active : (cnt_q >= limit);
    end
endmodule

// File: rtl/shdn_wake.sv
// Module: shutdown state and wake capture. Sets on a keyed request and clears
// on the first enabled wake, recording every source present in that cycle.
// Assumes the request and read flags are single-cycle pulses.
module shdn_wake
    import shdn_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_req,
    input  logic              stat_rd,
    input  logic [NPIN-1:0]   qual,
    input  logic [NPIN-1:0]   pin_en,
    input  logic              cal_i,
    input  logic              tick_i,
    input  logic              cal_en,
    input  logic              tick_en,
    output logic              shdn_o,
    output logic [DATA_W-1:0] stat_o
);
    logic [NPIN-1:0]   pin_hit;
    logic              cal_hit;
    logic              tick_hit;
    logic              wake;
    logic [DATA_W-1:0] cause;
    logic              shdn_q;
    logic [DATA_W-1:0] stat_q;

    // Qualify sources by their enables and by the shutdown state.
    always_comb begin
        pin_hit  = qual & pin_en;
        cal_hit  = cal_i & cal_en;
        tick_hit = tick_i & tick_en;
        wake     = shdn_q && ((|pin_hit) || cal_hit || tick_hit);
        cause    = '0;
        cause[ST_PIN_LSB +: NPIN] = pin_hit;
        cause[ST_CAL_BIT]         = cal_hit;
        cause[ST_TICK_BIT]        = tick_hit;
    end

    // Shutdown state register.
    always_ff @(posedge clk) begin
        if (!rst_n)        shdn_q <= 1'b0;
        else if (wake)     shdn_q <= 1'b0;
        else if (shdn_req) shdn_q <= 1'b1;
    end

    // Status capture on wake, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (wake)    stat_q <= cause;
        else if (stat_rd) stat_q <= '0;
    end

    assign shdn_o = shdn_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/shdn_wake_ctrl.sv
// Module: top of the shutdown and wake-up controller. Joins the register bank,
// the debouncer and the wake logic. Assumes one slow clock for everything.
module shdn_wake_ctrl
    import shdn_pkg::*;
#(
    parameter int NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPIN-1:0]   pins_i,
    input  logic              cal_alarm_i,
    input  logic              tick_alarm_i,
    output logic              shdn_o
);
    logic [IDX_W-1:0]  dbc_idx;
    logic              cal_en;
    logic              tick_en;
    logic [NPIN-1:0]   pin_en;
    logic [NPIN-1:0]   pin_pol;
    logic              shdn_req;
    logic              stat_rd;
    logic [NPIN-1:0]   qual;
    logic [DATA_W-1:0] status_w;

    shdn_regs #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .stat_i(status_w), .rdata(rdata),
        .dbc_idx(dbc_idx), .cal_en(cal_en), .tick_en(tick_en),
        .pin_en(pin_en), .pin_pol(pin_pol),
        .shdn_req(shdn_req), .stat_rd(stat_rd)
    );

    shdn_debounce #(.NPIN(NPIN)) u_dbc (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pin_pol(pin_pol),
        .dbc_idx(dbc_idx), .qual_o(qual)
    );

    shdn_wake #(.NPIN(NPIN)) u_wake (
        .clk(clk), .rst_n(rst_n), .shdn_req(shdn_req), .stat_rd(stat_rd),
        .qual(qual), .pin_en(pin_en), .cal_i(cal_alarm_i),
        .tick_i(tick_alarm_i), .cal_en(cal_en), .tick_en(tick_en),
        .shdn_o(shdn_o), .stat_o(status_w)
    );
endmodule

// File: rtl/shdn_wake_ctrl_chk.sv
// Module: property checker for the shutdown controller, bound to the top.
module shdn_wake_ctrl_chk
    import shdn_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              shdn_o,
    input logic [DATA_W-1:0] status
);
    logic keyed;
    logic stat_read;

    always_comb begin
        keyed     = wr_en && (addr == OFF_CTRL) && (wdata[31:24] == 8'hA5) && wdata[0];
        stat_read = rd_en && (addr == OFF_STAT);
    end

    AST_RISE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_o) |-> $past(keyed)); // R2
    AST_KEY_SETS_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
        (keyed && !shdn_o) |=> shdn_o); // R2
    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_o && !keyed) |=> !shdn_o); // R3
    AST_FALL_RECORDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shdn_o) |-> (status != '0)); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && !shdn_o) |=> (status == '0)); // R10
    AST_IDLE_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_o && !stat_read) |=> $stable(status)); // R11
endmodule

bind shdn_wake_ctrl shdn_wake_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .shdn_o(shdn_o), .status(status_w)
);

// File: tb/shdn_wake_ctrl_test.sv
// Bench: scoreboard style. Driver tasks push expected/observed items into a
// queue; a monitor pops and compares them on the falling clock edge.
module shdn_wake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pins_i = 16'hFFFE;
    logic        cal_alarm_i = 1'b0;
    logic        tick_alarm_i = 1'b0;
    logic        shdn_o;

    typedef struct {
        string       tag;
        logic [31:0] exp;
        logic [31:0] act;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    shdn_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pins_i(pins_i),
        .cal_alarm_i(cal_alarm_i), .tick_alarm_i(tick_alarm_i), .shdn_o(shdn_o)
    );

    // Monitor: pop queued items and compare.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (it.act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, it.act, it.exp);
            end
        end
    end

    task automatic push(input string tag, input logic [31:0] exp, input logic [31:0] act);
        item_t it;
        it.tag = tag; it.exp = exp; it.act = act;
        q.push_back(it);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_read(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        push(tag, exp, d);
    endtask

    // Count edges until shdn_o falls, giving up after lim edges.
    task automatic edges_to_wake(input int lim, output int n);
        n = 0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            n++;
            if (!shdn_o) break;
        end
    endtask

    task automatic go_down();
        bus_write(4'h0, 32'hA500_0001);
    endtask

    // Watchdog.
    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        push("R1 shdn", 32'd0, {31'd0, shdn_o});
        expect_read("R1 status", 4'h8, 32'h0);
        expect_read("R1 mode", 4'h4, 32'h0);
        expect_read("R1 pins", 4'hC, 32'h0);

        // R4 / R5: configuration readback
        bus_write(4'h4, 32'h0102_0000);          // index 1, calendar enable
        expect_read("R4 mode readback", 4'h4, 32'h0102_0000);
        bus_write(4'hC, 32'h0001_0009);          // pins 0,3 enabled; pin0 high, pin3 low
        expect_read("R5 pins readback", 4'hC, 32'h0001_0009);

        // R3: bad key and missing command bit
        bus_write(4'h0, 32'h5A00_0001);
        push("R3 wrong key", 32'd0, {31'd0, shdn_o});
        bus_write(4'h0, 32'hA500_0000);
        push("R3 bit0 clear", 32'd0, {31'd0, shdn_o});

        // R11: wake activity while powered is ignored
        pins_i[0] = 1'b1; cal_alarm_i = 1'b1;
        repeat (10) @(negedge clk);
        pins_i[0] = 1'b0; cal_alarm_i = 1'b0;
        push("R11 shdn idle", 32'd0, {31'd0, shdn_o});
        expect_read("R11 status idle", 4'h8, 32'h0);

        // R2: keyed shutdown
        go_down();
        push("R2 keyed write", 32'd1, {31'd0, shdn_o});

        // R6: one cycle short of the hold
        pins_i[0] = 1'b1;
        repeat (2) @(negedge clk);
        pins_i[0] = 1'b0;
        repeat (3) @(negedge clk);
        push("R6 short hold", 32'd1, {31'd0, shdn_o});

        // R7: broken level restarts the count
        pins_i[0] = 1'b1; repeat (2) @(negedge clk);
        pins_i[0] = 1'b0; @(negedge clk);
        pins_i[0] = 1'b1; repeat (2) @(negedge clk);
        pins_i[0] = 1'b0; repeat (3) @(negedge clk);
        push("R7 glitch restart", 32'd1, {31'd0, shdn_o});

        // R6/R8: full hold of 3 wakes at edge k+3
        pins_i[0] = 1'b1;
        edges_to_wake(20, n);
        pins_i[0] = 1'b0;
        push("R6 index1 edges", 32'd4, n);
        expect_read("R8 pin0 status", 4'h8, 32'h0001_0000);
        expect_read("R10 cleared", 4'h8, 32'h0);

        // R8: disabled pin (pin 5) does not wake
        go_down();
        pins_i[5] = 1'b0;
        repeat (10) @(negedge clk);
        pins_i[5] = 1'b1;
        push("R8 disabled pin", 32'd1, {31'd0, shdn_o});

        // R9: disabled timer alarm ignored, enabled calendar alarm wakes
        tick_alarm_i = 1'b1;
        repeat (5) @(negedge clk);
        push("R9 timer disabled", 32'd1, {31'd0, shdn_o});
        tick_alarm_i = 1'b0;
        cal_alarm_i = 1'b1;
        edges_to_wake(5, n);
        cal_alarm_i = 1'b0;
        push("R9 calendar edges", 32'd1, n);
        expect_read("R9 calendar status", 4'h8, 32'h0000_0020);

        // R9: timer alarm once enabled
        bus_write(4'h4, 32'h0001_0000);          // index 0, timer enable
        go_down();
        tick_alarm_i = 1'b1;
        edges_to_wake(5, n);
        tick_alarm_i = 1'b0;
        push("R9 timer edges", 32'd1, n);
        expect_read("R9 timer status", 4'h8, 32'h0000_0010);

        // R6/R5: index 0, active-low pin 3 wakes at once
        go_down();
        pins_i[3] = 1'b0;
        edges_to_wake(5, n);
        pins_i[3] = 1'b1;
        push("R6 index0 edges", 32'd1, n);
        expect_read("R5 pin3 low status", 4'h8, 32'h0008_0000);

        // R6: index 2 (32 cycles)
        bus_write(4'h4, 32'h0200_0000);
        go_down();
        pins_i[0] = 1'b1;
        edges_to_wake(100, n);
        pins_i[0] = 1'b0;
        push("R6 index2 edges", 32'd33, n);
        expect_read("R10 read after index2", 4'h8, 32'h0001_0000);

        // R6: index 5 (32768 cycles)
        bus_write(4'h4, 32'h0500_0000);
        go_down();
        pins_i[0] = 1'b1;
        edges_to_wake(40000, n);
        pins_i[0] = 1'b0;
        push("R6 index5 edges", 32'd32769, n);

        // R6: index 7 behaves as 5
        bus_write(4'h4, 32'h0700_0000);
        go_down();
        pins_i[0] = 1'b1;
        edges_to_wake(40000, n);
        pins_i[0] = 1'b0;
        push("R6 index7 edges", 32'd32769, n);
        expect_read("R10 status pin0", 4'h8, 32'h0001_0000);
        expect_read("R10 status clear", 4'h8, 32'h0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule